// File: doc/BRIEF.md
# Low-Power Mode and Oscillator Stabilization Controller

This block decides when the processor's oscillator runs, when the internal and output clocks are let through, and whether an external bus master may be granted the bus while the processor rests. Software writes a small control word holding a divide select for the master clock, a two-bit low-power mode code and a bus-release enable. A sleep-instruction strobe then moves the block out of the running state into one of five resting states. Which one is chosen depends on the I/O-stop flag and the mode code.

Two standby variants switch the oscillator off. On a wake event they restart it and hold the clock gate closed while a 17-bit counter covers the start-up time, which is long or short depending on the variant. With the bus-release enable set, a bus request in standby also restarts the oscillator. The bus is granted only once that wait has run out, and the block drops back to standby when the request goes away. Idle keeps the oscillator running with the gate closed, so a wake there reopens the clock at once.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (run), `osc_en`=1, `clk_gate_en`=1, `div2_sel`=1 and `bus_grant_ok`=0.
- R2: A write with `cfg_we`=1 in the run state loads the control word, laid out as bit 3 = bus-release enable, bits 2:1 = mode code (bit 2 high), bit 0 = no-divide. `div2_sel` equals the inverse of bit 0 from the next cycle on. Writes in any other state have no effect.
- R3: With `io_stop`=0, `sleep_stb` in run enters sleep (state 1) whatever the mode code. Oscillator and gate stay on, and `wake` returns to run.
- R4: With `io_stop`=1 and mode 00, `sleep_stb` enters system-stop (state 2). Oscillator and gate stay on.
- R5: With `io_stop`=1 and mode 01, `sleep_stb` enters idle (state 3), with `osc_en`=1 and `clk_gate_en`=0. A `wake` returns to run with the gate open on the next cycle.
- R6: With `io_stop`=1 and mode 10, `sleep_stb` enters standby (state 5), with `osc_en`=0 and `clk_gate_en`=0. A `wake` raises `osc_en` and enters warm-up (state 6). The gate opens, in run, exactly LONG_WAIT (131072) cycles after `osc_en` rises.
- R7: Mode 11 behaves as R6, but the wait is SHORT_WAIT (64) cycles.
- R8: A further `wake` during warm-up does not restart the count. The gate still opens LIM cycles after `osc_en` rose.
- R9: With the bus-release enable 0, `bus_req` in idle or standby has no effect: the state, `osc_en` and `bus_grant_ok`=0 all stay as they were.
- R10: With the bus-release enable 1, `bus_req` in standby starts warm-up. `bus_grant_ok` and the gate rise exactly LIM cycles later (state 7). When the request drops, the block returns to standby with `osc_en`=0.
- R11: With the bus-release enable 1, `bus_req` in idle grants on the next cycle and opens the gate (state 4). When the request drops, the block returns to idle.
- R12: In run, sleep and system-stop, `bus_grant_ok` follows `bus_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: [3] bus-release enable, [2:1] mode, [0] no-divide |
| sleep_stb | input | 1 | Sleep-instruction strobe |
| io_stop | input | 1 | I/O-stop flag |
| wake | input | 1 | Interrupt or reset wake event |
| bus_req | input | 1 | External bus request |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Gate enable for internal and output clocks |
| div2_sel | output | 1 | 1 = master clock is the crystal input divided by two |
| bus_grant_ok | output | 1 | Permission to grant the bus |
| pwr_state | output | 3 | State code: 0 run, 1 sleep, 2 system-stop, 3 idle, 4 idle-bus, 5 standby, 6 warm-up, 7 standby-bus |

## Verification
The hardest case to reach is a wake that lands during a warm-up that is already counting. The warm-up counter is internal, so the only place a restart would show up is in how long `clk_gate_en` stays low. The bench sets the short standby variant and enters standby. It raises `wake`, then raises it again a few cycles later, and counts edges from the rise of `osc_en` to the opening of the gate. A bus-started warm-up is reached the same way, with the release enable set, and the bench times `bus_grant_ok` from the rise of `osc_en`.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SLEEP    = 3'd1,
    ST_SYSSTOP  = 3'd2,
    ST_IDLE     = 3'd3,
    ST_IDLE_BUS = 3'd4,
    ST_STBY     = 3'd5,
    ST_WARM     = 3'd6,
    ST_STBY_BUS = 3'd7
  } lp_state_e;

  typedef struct packed {
    logic       bus_exit;
    logic [1:0] mode;
    logic       nodiv;
  } lp_cfg_t;

  localparam int CFG_W = $bits(lp_cfg_t);
endpackage

// File: rtl/lpclk_cfg_reg.sv
module lpclk_cfg_reg
  import lpclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             wr_ok,
  input  logic [CFG_W-1:0] wdata,
  output lp_cfg_t          cfg,
  output logic             div2_sel
);
  lp_cfg_t wr_val;
  assign wr_val = lp_cfg_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      div2_sel <= 1'b1;
    end else if (we && wr_ok) begin
      cfg      <= wr_val;
      div2_sel <= ~wr_val.nodiv;
    end
  end
endmodule

// File: rtl/lpclk_stab_timer.sv
module lpclk_stab_timer #(
  parameter int LONG_WAIT  = 131072,
  parameter int SHORT_WAIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic short_sel,
  output logic done
);
  localparam int CNT_W = $clog2(LONG_WAIT);
  localparam logic [CNT_W-1:0] LONG_TGT  = CNT_W'(LONG_WAIT - 2);
  localparam logic [CNT_W-1:0] SHORT_TGT = CNT_W'(SHORT_WAIT - 2);

  logic [CNT_W-1:0] cnt;
  logic             fin;
  logic [CNT_W-1:0] tgt;
  logic             hit;

  assign tgt = short_sel ? SHORT_TGT : LONG_TGT;
  assign hit = run && !fin && (cnt == tgt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      fin  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= hit;
      if (hit) fin <= 1'b1;
      if (run && !fin) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lpclk_mode_fsm.sv
module lpclk_mode_fsm
  import lpclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lp_cfg_t   cfg,
  input  logic      sleep_stb,
  input  logic      io_stop,
  input  logic      wake,
  input  logic      bus_req,
  input  logic      tmr_done,
  output logic      tmr_clr,
  output logic      tmr_run,
  output logic      osc_en,
  output logic      clk_gate_en,
  output logic      bus_grant_ok,
  output lp_state_e state
);
  lp_state_e ns;
  logic      dest_run, dest_run_n;
  logic      osc_n, gate_n, grant_n;

  always_comb begin
    ns         = state;
    dest_run_n = dest_run;
    unique case (state)
      ST_RUN: begin
        if (sleep_stb) begin
          if (!io_stop) ns = ST_SLEEP;
          else begin
            unique case (cfg.mode)
              2'b00:   ns = ST_SYSSTOP;
              2'b01:   ns = ST_IDLE;
              default: ns = ST_STBY;
            endcase
          end
        end
      end
      ST_SLEEP, ST_SYSSTOP: if (wake) ns = ST_RUN;
      ST_IDLE: begin
        if (wake) ns = ST_RUN;
        else if (cfg.bus_exit && bus_req) ns = ST_IDLE_BUS;
      end
      ST_IDLE_BUS: begin
        if (wake) ns = ST_RUN;
        else if (!bus_req) ns = ST_IDLE;
      end
      ST_STBY: begin
        if (wake) begin
          ns = ST_WARM; dest_run_n = 1'b1;
        end else if (cfg.bus_exit && bus_req) begin
          ns = ST_WARM; dest_run_n = 1'b0;
        end
      end
      ST_WARM: begin
        if (wake) dest_run_n = 1'b1;
        if (tmr_done) ns = (dest_run || wake) ? ST_RUN : ST_STBY_BUS;
        else if (!dest_run && !wake && !bus_req) ns = ST_STBY;
      end
      ST_STBY_BUS: begin
        if (wake) ns = ST_RUN;
        else if (!bus_req) ns = ST_STBY;
      end
      default: ns = ST_RUN;
    endcase
  end

  always_comb begin
    osc_n   = (ns != ST_STBY);
    gate_n  = (ns == ST_RUN) || (ns == ST_SLEEP) || (ns == ST_SYSSTOP) ||
              (ns == ST_IDLE_BUS) || (ns == ST_STBY_BUS);
    grant_n = (((ns == ST_RUN) || (ns == ST_SLEEP) || (ns == ST_SYSSTOP)) && bus_req) ||
              (ns == ST_IDLE_BUS) || (ns == ST_STBY_BUS);
  end

  assign tmr_clr = (ns == ST_WARM) && (state != ST_WARM);
  assign tmr_run = (state == ST_WARM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      dest_run     <= 1'b0;
      osc_en       <= 1'b1;
      clk_gate_en  <= 1'b1;
      bus_grant_ok <= 1'b0;
    end else begin
      state        <= ns;
      dest_run     <= dest_run_n;
      osc_en       <= osc_n;
      clk_gate_en  <= gate_n;
      bus_grant_ok <= grant_n;
    end
  end
endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
  import lpclk_pkg::*;
#(
  parameter int LONG_WAIT  = 131072,
  parameter int SHORT_WAIT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       sleep_stb,
  input  logic       io_stop,
  input  logic       wake,
  input  logic       bus_req,
  output logic       osc_en,
  output logic       clk_gate_en,
  output logic       div2_sel,
  output logic       bus_grant_ok,
  output logic [2:0] pwr_state
);
  lp_cfg_t   cfg;
  lp_state_e state;
  logic      tmr_clr, tmr_run, tmr_done;

  lpclk_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wr_ok    (state == ST_RUN),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .div2_sel (div2_sel)
  );

  lpclk_stab_timer #(.LONG_WAIT(LONG_WAIT), .SHORT_WAIT(SHORT_WAIT)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .clr       (tmr_clr),
    .run       (tmr_run),
    .short_sel (cfg.mode == 2'b11),
    .done      (tmr_done)
  );

  lpclk_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cfg          (cfg),
    .sleep_stb    (sleep_stb),
    .io_stop      (io_stop),
    .wake         (wake),
    .bus_req      (bus_req),
    .tmr_done     (tmr_done),
    .tmr_clr      (tmr_clr),
    .tmr_run      (tmr_run),
    .osc_en       (osc_en),
    .clk_gate_en  (clk_gate_en),
    .bus_grant_ok (bus_grant_ok),
    .state        (state)
  );

  assign pwr_state = state;
endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk #(
  parameter int LONG_WAIT = 131072
) (
  input logic       clk,
  input logic       rst,
  input logic       osc_en,
  input logic       clk_gate_en,
  input logic       div2_sel,
  input logic       bus_grant_ok,
  input logic [2:0] pwr_state
);
  logic [31:0] warm_cnt;

  always_ff @(posedge clk) begin
    if (rst) warm_cnt <= '0;
    else if (pwr_state == 3'd6) warm_cnt <= warm_cnt + 1;
    else warm_cnt <= '0;
  end

  AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !clk_gate_en); // R6

  AST_IDLE_OSC_ON_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd3) |-> (osc_en && !clk_gate_en)); // R5

  AST_STBY_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd5) |-> (!bus_grant_ok && !osc_en)); // R9

  AST_DIV_FROZEN_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 3'd0) |=> $stable(div2_sel)); // R2

  AST_WARM_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd6) |-> (osc_en && !clk_gate_en && !bus_grant_ok)); // R8

  AST_WARM_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd6) |-> (warm_cnt < LONG_WAIT)); // R6

  AST_STBY_BUS_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd7) |-> (bus_grant_ok && clk_gate_en)); // R10
endmodule

bind lpclk_ctrl lpclk_ctrl_chk #(.LONG_WAIT(LONG_WAIT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .osc_en       (osc_en),
  .clk_gate_en  (clk_gate_en),
  .div2_sel     (div2_sel),
  .bus_grant_ok (bus_grant_ok),
  .pwr_state    (pwr_state)
);

// File: tb/lpclk_ctrl_bench.sv
`timescale 1ns/1ps
module lpclk_ctrl_bench;
  localparam int LW = 131072;
  localparam int SW = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       sleep_stb = 1'b0;
  logic       io_stop = 1'b0;
  logic       wake = 1'b0;
  logic       bus_req = 1'b0;
  logic       osc_en, clk_gate_en, div2_sel, bus_grant_ok;
  logic [2:0] pwr_state;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lpclk_ctrl u_lpclk_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sleep_stb(sleep_stb), .io_stop(io_stop), .wake(wake), .bus_req(bus_req),
    .osc_en(osc_en), .clk_gate_en(clk_gate_en), .div2_sel(div2_sel),
    .bus_grant_ok(bus_grant_ok), .pwr_state(pwr_state)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_cfg(input logic bex, input logic [1:0] mode, input logic nodiv);
    cfg_we = 1'b1; cfg_wdata = {bex, mode, nodiv};
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_sleep(input logic io);
    sleep_stb = 1'b1; io_stop = io;
    step();
    sleep_stb = 1'b0; io_stop = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    step();
    wake = 1'b0;
  endtask

  task automatic wait_gate(output int n, input int cap);
    n = 0;
    while (!clk_gate_en && n < cap) begin step(); n++; end
  endtask

  task automatic t_reset();
    check("R1 state", pwr_state, 0);
    check("R1 osc", osc_en, 1);
    check("R1 gate", clk_gate_en, 1);
    check("R1 div2", div2_sel, 1);
    check("R1 grant", bus_grant_ok, 0);
  endtask

  task automatic t_divide();
    wr_cfg(1'b0, 2'b00, 1'b1);
    check("R2 div2 after nodiv=1", div2_sel, 0);
    wr_cfg(1'b0, 2'b00, 1'b0);
    check("R2 div2 after nodiv=0", div2_sel, 1);
    do_sleep(1'b0);
    wr_cfg(1'b0, 2'b00, 1'b1);
    check("R2 write in sleep ignored", div2_sel, 1);
    pulse_wake();
    check("R2 still ignored after wake", div2_sel, 1);
  endtask

  task automatic t_sleep_plain();
    wr_cfg(1'b0, 2'b10, 1'b0);
    do_sleep(1'b0);
    check("R3 sleep state", pwr_state, 1);
    check("R3 osc", osc_en, 1);
    check("R3 gate", clk_gate_en, 1);
    pulse_wake();
    check("R3 back to run", pwr_state, 0);
  endtask

  task automatic t_sysstop();
    wr_cfg(1'b0, 2'b00, 1'b0);
    do_sleep(1'b1);
    check("R4 sysstop state", pwr_state, 2);
    check("R4 osc/gate", {osc_en, clk_gate_en}, 3);
    pulse_wake();
    check("R4 back to run", pwr_state, 0);
  endtask

  task automatic t_idle();
    wr_cfg(1'b0, 2'b01, 1'b0);
    do_sleep(1'b1);
    check("R5 idle state", pwr_state, 3);
    check("R5 idle osc/gate", {osc_en, clk_gate_en}, 2);
    pulse_wake();
    check("R5 gate reopens next cycle", clk_gate_en, 1);
    check("R5 run", pwr_state, 0);
  endtask

  task automatic t_standby(input logic [1:0] mode, input int lim, input string req);
    int n;
    wr_cfg(1'b0, mode, 1'b0);
    do_sleep(1'b1);
    check({req, " standby state"}, pwr_state, 5);
    check({req, " osc/gate off"}, {osc_en, clk_gate_en}, 0);
    pulse_wake();
    check({req, " osc restarts"}, osc_en, 1);
    check({req, " warm state"}, pwr_state, 6);
    wait_gate(n, lim + 10);
    check({req, " stabilization cycles"}, n, lim);
    check({req, " run after warm"}, pwr_state, 0);
  endtask

  task automatic t_wake_during_warm();
    int n;
    wr_cfg(1'b0, 2'b11, 1'b0);
    do_sleep(1'b1);
    pulse_wake();
    repeat (9) step();
    wake = 1'b1; step(); wake = 1'b0;
    check("R8 still warming", pwr_state, 6);
    wait_gate(n, SW + 10);
    check("R8 count not restarted", n + 10, SW);
  endtask

  task automatic t_bus_ignored();
    wr_cfg(1'b0, 2'b11, 1'b0);
    do_sleep(1'b1);
    bus_req = 1'b1;
    repeat (5) step();
    check("R9 standby state kept", pwr_state, 5);
    check("R9 standby osc/grant", {osc_en, bus_grant_ok}, 0);
    bus_req = 1'b0;
    pulse_wake();
    repeat (SW) step();
    wr_cfg(1'b0, 2'b01, 1'b0);
    do_sleep(1'b1);
    bus_req = 1'b1;
    repeat (3) step();
    check("R9 idle state kept", pwr_state, 3);
    check("R9 idle grant/gate", {bus_grant_ok, clk_gate_en}, 0);
    bus_req = 1'b0;
    pulse_wake();
  endtask

  task automatic t_bus_stby();
    int n;
    wr_cfg(1'b1, 2'b11, 1'b0);
    do_sleep(1'b1);
    bus_req = 1'b1;
    step();
    check("R10 osc restarts on bus_req", osc_en, 1);
    check("R10 no early grant", bus_grant_ok, 0);
    n = 0;
    while (!bus_grant_ok && n < SW + 10) begin step(); n++; end
    check("R10 grant delay", n, SW);
    check("R10 standby-bus state", pwr_state, 7);
    check("R10 gate open", clk_gate_en, 1);
    bus_req = 1'b0;
    step();
    check("R10 back to standby", pwr_state, 5);
    check("R10 osc/grant off", {osc_en, bus_grant_ok}, 0);
    pulse_wake();
    wait_gate(n, SW + 10);
    check("R10 wake afterwards", pwr_state, 0);
  endtask

  task automatic t_bus_idle();
    wr_cfg(1'b1, 2'b01, 1'b0);
    do_sleep(1'b1);
    bus_req = 1'b1;
    step();
    check("R11 idle-bus state", pwr_state, 4);
    check("R11 grant/gate", {bus_grant_ok, clk_gate_en}, 3);
    bus_req = 1'b0;
    step();
    check("R11 back to idle", pwr_state, 3);
    check("R11 grant/gate off", {bus_grant_ok, clk_gate_en}, 0);
    pulse_wake();
  endtask

  task automatic t_bus_run();
    bus_req = 1'b1;
    check("R12 not yet granted", bus_grant_ok, 0);
    step();
    check("R12 granted in run", bus_grant_ok, 1);
    bus_req = 1'b0;
    step();
    check("R12 released in run", bus_grant_ok, 0);
    do_sleep(1'b0);
    bus_req = 1'b1;
    step();
    check("R12 granted in sleep", bus_grant_ok, 1);
    bus_req = 1'b0;
    pulse_wake();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_divide();
    t_sleep_plain();
    t_sysstop();
    t_idle();
    t_standby(2'b11, SW, "R7");
    t_wake_during_warm();
    t_bus_ignored();
    t_bus_stby();
    t_bus_idle();
    t_bus_run();
    t_standby(2'b10, LW, "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule